// File: doc/BRIEF.md
# Clock Activity Status and Lock Monitor

This block watches two clocks, an incoming reference clock and a synthesized output clock, from a free-running monitor clock. It reports on an 8-bit status bus whether either of them has stopped toggling. It also drives a lock flag that follows a behavioural lock-indication input. The real delay line, phase alignment and frequency synthesis are not part of the block. A lock-indication input and the bench's own clocks stand in for them.

Each stopped-clock bit is reported only when its connection-enable input says the matching clock path is in use. The block has one asynchronous, active-high reset request. It is qualified in the reference domain and acts only after it has been held high for a minimum number of reference cycles. A qualified reset clears the activity detectors, the status bus and the lock flag. It leaves the multiply and divide setting registers unchanged.

Top module: `clk_status_monitor`

## Requirements
- R1: A reset request held high for at least RST_MIN (3) reference cycles resets the block. A request shorter than one reference cycle is ignored: the lock flag and the status bus keep their values.
- R2: While a qualified reset is in effect, `locked` is low and `status` reads 0.
- R3: `locked` rises only after `lock_ind` has been high for LOCK_CYCLES (8) consecutive reference cycles after reset release. It falls within a few reference cycles of `lock_ind` going low.
- R4: Status bit 1 goes high when no reference edge has been seen for STOP_TIMEOUT (16) monitor cycles and `fb_conn` is high. It is still low 8 monitor cycles after the reference clock halts.
- R5: A set stopped bit clears within a few monitor cycles of the next detected edge of its clock.
- R6: Status bit 2 reports that the synthesized clock has stopped, under the same timeout, only while `fx_used` is high. With `fx_used` low it reads 0.
- R7: With `fb_conn` low, status bit 1 never asserts, even when the reference clock stops.
- R8: Status bits 0 and 3 to 7 always read 0.
- R9: The multiply and divide settings load on `cfg_we` and are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| ref_clk | input | 1 | Reference clock under watch |
| fx_clk | input | 1 | Synthesized clock under watch |
| rst_req | input | 1 | Asynchronous active-high reset request |
| lock_ind | input | 1 | Behavioural lock indication |
| fb_conn | input | 1 | Feedback path connected; enables bit 1 |
| fx_used | input | 1 | Synthesized output in use; enables bit 2 |
| cfg_we | input | 1 | Load strobe for settings (monitor domain) |
| cfg_mul | input | MUL_W | Multiply setting to load |
| cfg_div | input | DIV_W | Divide setting to load |
| status | output | 8 | Status bus, bit 1 reference stopped, bit 2 synthesized stopped |
| locked | output | 1 | Lock flag (reference domain) |
| mul_q | output | MUL_W | Held multiply setting |
| div_q | output | DIV_W | Held divide setting |

## Verification
Directed cases halt each clock with its enable high and with it low, then sample both before and after the timeout. This separates a correct timeout from an early flag and from missing gating. Randomised trials pick each enable and each clock's running state independently, and compare the whole bus against a bench model. This catches swapped bits, wrong gating and stray reserved bits. The reset tests contrast a sub-cycle pulse with a long hold. They tell qualification apart from a plain asynchronous reset, and they also show that the settings survive a reset.

// File: rtl/clkmon_pkg.sv
// Shared constants for the clock status monitor.
// Assumes an 8-bit status bus with two live bit positions.
package clkmon_pkg;
    localparam int STAT_W       = 8;
    localparam int BIT_REF_STOP = 1;
    localparam int BIT_FX_STOP  = 2;
    localparam logic [STAT_W-1:0] LIVE_MASK = 8'b0000_0110;
    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/clkmon_sync.sv
// Multi-flop synchronizer carrying one bit into the clk domain.
// Assumes the input is a level or a slow clock. No reset: it flushes in STAGES cycles.
module clkmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_activity.sv
// Edge-activity detector: flags a watched clock as stopped after TIMEOUT
// monitor cycles without a transition, and clears the flag on the next one.
// Assumes the watched clock holds each level for at least one monitor cycle.
module clkmon_activity #(
    parameter int TIMEOUT = 16,
    parameter int STAGES  = 2
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic watch_clk,
    output logic stopped
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic          lvl_s;
    logic          lvl_prev;
    logic          edge_seen;
    logic [CW-1:0] quiet_cnt;

    clkmon_sync #(.STAGES(STAGES)) u_sync (
        .clk (mon_clk),
        .d   (watch_clk),
        .q   (lvl_s)
    );

    assign edge_seen = lvl_s ^ lvl_prev;

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge mon_clk) begin
        lvl_prev <= lvl_s;
    end

    // Count quiet monitor cycles and raise the stopped flag at the limit.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
            stopped   <= 1'b0;
        end else if (edge_seen) begin
            quiet_cnt <= '0;
            stopped   <= 1'b0;
        end else if (quiet_cnt == CW'(TIMEOUT - 1)) begin
            stopped   <= 1'b1;
        end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R5: an observed edge always clears the flag on the next cycle.
    a_r5_edge_clears: assert property (@(posedge mon_clk) disable iff (!rst_n)
        edge_seen |=> !stopped);

    // R4: the flag never rises in a cycle that followed an edge.
    a_r4_rise_after_quiet: assert property (@(posedge mon_clk) disable iff (!rst_n)
        $rose(stopped) |-> !$past(edge_seen));

    // R4: the quiet counter stays inside its window.
    a_r4_cnt_bounded: assert property (@(posedge mon_clk) disable iff (!rst_n)
        quiet_cnt <= CW'(TIMEOUT - 1));
endmodule

// File: rtl/clkmon_rst_lock.sv
// Reference-domain reset qualifier and lock flag.
// The reset request counts only after RST_MIN consecutive high reference samples.
// The lock flag needs LOCK_CYCLES consecutive high lock-indication samples.
// Assumes the reference clock runs whenever a reset is to be honoured.
module clkmon_rst_lock #(
    parameter int RST_MIN     = 3,
    parameter int LOCK_CYCLES = 8,
    parameter int STAGES      = 2
) (
    input  logic ref_clk,
    input  logic rst_req,
    input  logic lock_ind,
    output logic rst_q,
    output logic locked
);
    localparam int RCW = $clog2(RST_MIN + 1);
    localparam int LCW = $clog2(LOCK_CYCLES + 1);

    logic           req_s;
    logic           lk_s;
    logic [RCW-1:0] hold_cnt;
    logic [LCW-1:0] stable_cnt;
    logic           ref_rst_n;

    clkmon_sync #(.STAGES(STAGES)) u_req_sync (
        .clk (ref_clk),
        .d   (rst_req),
        .q   (req_s)
    );

    clkmon_sync #(.STAGES(STAGES)) u_lk_sync (
        .clk (ref_clk),
        .d   (lock_ind),
        .q   (lk_s)
    );

    // Count consecutive high samples of the reset request, saturating.
    always_ff @(posedge ref_clk) begin
        if (!req_s) begin
            hold_cnt <= '0;
        end else if (hold_cnt != RCW'(RST_MIN)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Register the qualified reset so it can cross domains glitch-free.
    always_ff @(posedge ref_clk) begin
        rst_q <= req_s && (hold_cnt >= RCW'(RST_MIN - 1));
    end

    assign ref_rst_n = ~rst_q;

    // Raise lock after a long enough run of lock indication, drop it at once.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            stable_cnt <= '0;
            locked     <= 1'b0;
        end else if (!lk_s) begin
            stable_cnt <= '0;
            locked     <= 1'b0;
        end else if (stable_cnt == LCW'(LOCK_CYCLES - 1)) begin
            locked     <= 1'b1;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end

    // R2: a qualified reset forces the lock flag low.
    a_r2_lock_low_in_reset: assert property (@(posedge ref_clk)
        rst_q |=> !locked);

    // R1: the qualified reset only rises after a run of high request samples.
    a_r1_needs_hold: assert property (@(posedge ref_clk)
        $rose(rst_q) |-> ($past(req_s) && $past(req_s, 2)));

    // R3: lock rises only after a run of high lock indication.
    a_r3_lock_needs_run: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(locked) |-> ($past(lk_s) && $past(lk_s, 2)));
endmodule

// File: rtl/clk_status_monitor.sv
// Top of the clock status and lock monitor.
// Watches the reference and synthesized clocks from mon_clk, reports gated
// stopped flags on an 8-bit bus, and drives the lock flag in the reference domain.
// Assumes mon_clk runs at least twice as fast as either watched clock.
module clk_status_monitor #(
    parameter int STOP_TIMEOUT = 16,
    parameter int RST_MIN      = 3,
    parameter int LOCK_CYCLES  = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int MUL_W        = 5,
    parameter int DIV_W        = 5
) (
    input  logic             mon_clk,
    input  logic             ref_clk,
    input  logic             fx_clk,
    input  logic             rst_req,
    input  logic             lock_ind,
    input  logic             fb_conn,
    input  logic             fx_used,
    input  logic             cfg_we,
    input  logic [MUL_W-1:0] cfg_mul,
    input  logic [DIV_W-1:0] cfg_div,
    output logic [7:0]       status,
    output logic             locked,
    output logic [MUL_W-1:0] mul_q,
    output logic [DIV_W-1:0] div_q
);
    import clkmon_pkg::*;

    localparam int N_WATCH = 2;

    logic               rst_q_ref;
    logic               rst_q_mon;
    logic               mon_rst_n;
    logic [N_WATCH-1:0] watch_clks;
    logic [N_WATCH-1:0] watch_stop;
    logic [N_WATCH-1:0] watch_en;
    stat_t              status_nxt;

    clkmon_rst_lock #(
        .RST_MIN     (RST_MIN),
        .LOCK_CYCLES (LOCK_CYCLES),
        .STAGES      (SYNC_STAGES)
    ) u_rst_lock (
        .ref_clk  (ref_clk),
        .rst_req  (rst_req),
        .lock_ind (lock_ind),
        .rst_q    (rst_q_ref),
        .locked   (locked)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk (mon_clk),
        .d   (rst_q_ref),
        .q   (rst_q_mon)
    );

    assign mon_rst_n  = ~rst_q_mon;
    assign watch_clks = {fx_clk, ref_clk};
    assign watch_en   = {fx_used, fb_conn};

    generate
        for (genvar i = 0; i < N_WATCH; i++) begin : g_watch
            clkmon_activity #(
                .TIMEOUT (STOP_TIMEOUT),
                .STAGES  (SYNC_STAGES)
            ) u_act (
                .mon_clk   (mon_clk),
                .rst_n     (mon_rst_n),
                .watch_clk (watch_clks[i]),
                .stopped   (watch_stop[i])
            );
        end
    endgenerate

    // Place each gated stopped flag in its bus position; the rest stay zero.
    always_comb begin
        status_nxt               = '0;
        status_nxt[BIT_REF_STOP] = watch_stop[0] & watch_en[0];
        status_nxt[BIT_FX_STOP]  = watch_stop[1] & watch_en[1];
    end

    // Register the status bus in the monitor domain.
    always_ff @(posedge mon_clk) begin
        if (!mon_rst_n) begin
            status <= '0;
        end else begin
            status <= status_nxt;
        end
    end

    // Hold the settings; reset deliberately does not touch them.
    always_ff @(posedge mon_clk) begin
        if (cfg_we) begin
            mul_q <= cfg_mul;
            div_q <= cfg_div;
        end
    end

    // R8: reserved positions never carry a one.
    a_r8_reserved_zero: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (status & ~LIVE_MASK) == '0);

    // R7: without the feedback path the reference bit stays low.
    a_r7_ref_gated: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        !$past(fb_conn) |-> !status[BIT_REF_STOP]);

    // R6: without the synthesized path in use its bit stays low.
    a_r6_fx_gated: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        !$past(fx_used) |-> !status[BIT_FX_STOP]);

    // R9: settings change only on a load strobe.
    a_r9_cfg_held: assert property (@(posedge mon_clk)
        !$past(cfg_we) |-> ($stable(mul_q) && $stable(div_q)));
endmodule

// File: tb/tb_clk_status_monitor.sv
module tb_clk_status_monitor;
    localparam int MUL_W = 5;
    localparam int DIV_W = 5;

    logic             mon_clk = 0, ref_clk = 0, fx_clk = 0;
    logic             ref_run = 1, fx_run = 1;
    logic             rst_req = 1, lock_ind = 1, fb_conn = 1, fx_used = 1, cfg_we = 0;
    logic [MUL_W-1:0] cfg_mul = '0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [7:0]       status;
    logic             locked;
    logic [MUL_W-1:0] mul_q;
    logic [DIV_W-1:0] div_q;

    int checks = 0;
    int fails  = 0;
    logic [MUL_W-1:0] keep_mul;
    logic [DIV_W-1:0] keep_div;

    clk_status_monitor dut (
        .mon_clk (mon_clk), .ref_clk (ref_clk), .fx_clk (fx_clk),
        .rst_req (rst_req), .lock_ind (lock_ind), .fb_conn (fb_conn),
        .fx_used (fx_used), .cfg_we (cfg_we), .cfg_mul (cfg_mul),
        .cfg_div (cfg_div), .status (status), .locked (locked),
        .mul_q (mul_q), .div_q (div_q)
    );

    always #10 mon_clk = ~mon_clk;
    always #40 if (ref_run) ref_clk = ~ref_clk;
    always #30 if (fx_run) fx_clk = ~fx_clk;

    function automatic logic [7:0] exp_status(input logic ref_stop, input logic fx_stop,
                                              input logic fb, input logic fxu);
        logic [7:0] e;
        e    = 8'h00;
        e[1] = ref_stop & fb;
        e[2] = fx_stop & fxu;
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_mon(input int n);
        repeat (n) @(negedge mon_clk);
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R2: held reset forces lock low and status to zero
        wait_ref(10);
        chk("R2 lock in reset", 32'(locked), 0);
        chk("R2 status in reset", 32'(status), 0);
        rst_req = 0;
        wait_ref(3);
        chk("R3 lock early after release", 32'(locked), 0);
        wait_ref(20);
        chk("R3 lock after stable run", 32'(locked), 1);
        chk("R8 idle status", 32'(status), 0);

        // R9: load settings
        @(negedge mon_clk);
        cfg_mul = MUL_W'($urandom); cfg_div = DIV_W'($urandom); cfg_we = 1;
        keep_mul = cfg_mul; keep_div = cfg_div;
        @(negedge mon_clk);
        cfg_we = 0; cfg_mul = ~keep_mul; cfg_div = ~keep_div;
        wait_mon(2);
        chk("R9 mul load", 32'(mul_q), 32'(keep_mul));
        chk("R9 div load", 32'(div_q), 32'(keep_div));

        // R4/R5: reference stop with feedback connected
        ref_run = 0;
        wait_mon(8);
        chk("R4 no early ref flag", 32'(status[1]), 0);
        wait_mon(40);
        chk("R4 ref stopped", 32'(status), 32'(exp_status(1, 0, 1, 1)));
        ref_run = 1;
        wait_mon(10);
        chk("R5 ref restart clears", 32'(status), 0);

        // R7: no feedback path, reference stops
        fb_conn = 0; ref_run = 0;
        wait_mon(48);
        chk("R7 ref bit gated", 32'(status), 0);
        ref_run = 1; fb_conn = 1;
        wait_mon(10);

        // R6: synthesized clock stop, then disable its path
        fx_run = 0;
        wait_mon(48);
        chk("R6 fx stopped", 32'(status), 32'(exp_status(0, 1, 1, 1)));
        fx_used = 0;
        wait_mon(3);
        chk("R6 fx bit gated", 32'(status), 0);
        fx_used = 1;
        wait_mon(3);
        fx_run = 1;
        wait_mon(10);
        chk("R5 fx restart clears", 32'(status), 0);

        // R3: lock follows a dropped and restored indication
        lock_ind = 0;
        wait_ref(5);
        chk("R3 lock drops", 32'(locked), 0);
        lock_ind = 1;
        wait_ref(4);
        chk("R3 lock not yet", 32'(locked), 0);
        wait_ref(12);
        chk("R3 lock back", 32'(locked), 1);

        // R1: a short pulse is ignored
        fx_run = 0;
        wait_mon(48);
        @(negedge ref_clk);
        #10 rst_req = 1;
        #50 rst_req = 0;
        wait_ref(10);
        chk("R1 short pulse lock kept", 32'(locked), 1);
        chk("R1 short pulse status kept", 32'(status), 32'(exp_status(0, 1, 1, 1)));

        // R1/R2/R9: a long hold resets, settings survive
        rst_req = 1;
        wait_ref(8);
        chk("R1 long hold drops lock", 32'(locked), 0);
        chk("R2 status cleared", 32'(status), 0);
        rst_req = 0;
        wait_ref(25);
        chk("R9 mul kept over reset", 32'(mul_q), 32'(keep_mul));
        chk("R9 div kept over reset", 32'(div_q), 32'(keep_div));
        chk("R3 relock after reset", 32'(locked), 1);
        wait_mon(48);
        chk("R6 fx redetected", 32'(status), 32'(exp_status(0, 1, 1, 1)));
        fx_run = 1;
        wait_mon(10);

        // R4/R6/R7/R8: random enables and stopped clocks against the model
        for (int t = 0; t < 10; t++) begin
            logic [3:0] r;
            r = 4'($urandom);
            fb_conn = r[0]; fx_used = r[1];
            ref_run = ~r[2]; fx_run = ~r[3];
            wait_mon(60);
            chk("R8 random status", 32'(status), 32'(exp_status(r[2], r[3], r[0], r[1])));
            ref_run = 1; fx_run = 1;
            wait_mon(12);
            chk("R5 random recovery", 32'(status), 0);
        end
        finish_run();
    end
endmodule